// File: doc/BRIEF.md
# 64-bit Multi-Channel Timer Bank

This block holds a bank of independent 64-bit down-counting timers behind a 32-bit register port. Each timer has a 64-bit limit and a 64-bit live count. Both are visible as separate low and high 32-bit words. One shared control word holds a run bit for each timer. A running timer counts down once per clock. When it reaches zero it reloads from its limit and raises a one-cycle pulse on its own bit of `tmr_irq`. Bit i of `tmr_irq` is meant to feed interrupt source i+1 of a downstream controller, and that routing lies outside this block.

The intended clock is the controller clock of 66,666,666 Hz. Software sets the limit while a timer is stopped, because a limit write to a stopped timer also presets the count. It then sets the run bit. The count halves are read separately and carry no snapshot. A borrow from the high half therefore shows up between two reads of that half. This lets software rebuild a consistent 64-bit value by reading the high word, then the low word, then the high word again.

Top module: `tmr_bank`

## Requirements
- R1: After a synchronous active-high reset, the control word, every limit and every count read as 0, and `tmr_irq` is all zeros.
- R2: The control word at offset 0x000 stores and reads back all 32 bits. Bit 8+i is the run bit of timer i. Bits 7:0 and 31:16 start no timer.
- R3: The limit of timer i is read and written at word offsets 0x100+i (bits 31:0) and 0x110+i (bits 63:32).
- R4: A limit write to a stopped timer also copies the written word into the same half of its count. A limit write to a running timer leaves the count sequence unchanged.
- R5: A running timer's count decreases by exactly one per clock. Its halves read live at 0x120+i (low) and 0x130+i (high), so a borrow into the high half is seen between two high-word reads.
- R6: In the clock after a running timer's count was 0, the count holds the limit and `tmr_irq[i]` is 1 for that one cycle. A limit of N gives a period of N+1 clocks, and a limit of 0 pulses every clock.
- R7: A stopped timer holds its count.
- R8: Writes to the count offsets are ignored.
- R9: Read data appears on `rdata` in the clock after `rd_en`. Offsets with no register behind them read as 0.
- R10: Timers run independently. Bit i of `tmr_irq` belongs only to timer i, and several bits may pulse in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (9) | Word offset of the access |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Registered read data |
| tmr_irq | output | NTMR (8) | One-cycle expiry pulse per timer |

## Verification
The first pattern uses a limit of 4 on one timer. It shows whether the period is N+1 rather than N, and whether a stop written mid-period freezes the count at the exact value. The second pattern uses a limit of 0 on one timer alongside a limit of 2 on another. It separates a continuous pulse train from a periodic one and checks that coincident pulses land on the right bits. The third pattern uses a count just above 2^32. Its high/low/high reads expose the borrow between the halves. A limit write during that run shows that a running count is not disturbed. Stopped timers are probed with limit writes, count writes and control values whose only set bits are outside the run field. This tells preset, ignore and hold apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Word offsets of the register groups; one word per timer within a group.
  localparam int unsigned CTRL_OFS  = 'h000;
  localparam int unsigned MAXLO_OFS = 'h100;
  localparam int unsigned MAXHI_OFS = 'h110;
  localparam int unsigned CNTLO_OFS = 'h120;
  localparam int unsigned CNTHI_OFS = 'h130;
  localparam int unsigned GRP_SPAN  = 16;
  // Position of the run bit of timer 0 inside the control word.
  localparam int unsigned RUN_LSB   = 8;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int NTMR = 8,
  parameter int AW   = 9
) (
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  output logic            ctrl_wr,
  output logic [NTMR-1:0] lo_wr,
  output logic [NTMR-1:0] hi_wr
);
  assign ctrl_wr = wr_en && (addr == AW'(CTRL_OFS));

  for (genvar i = 0; i < NTMR; i++) begin : g_dec
    assign lo_wr[i] = wr_en && (addr == AW'(MAXLO_OFS + i));
    assign hi_wr[i] = wr_en && (addr == AW'(MAXHI_OFS + i));
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic [DW-1:0] wdata,
  output logic [2*DW-1:0] max_q,
  output logic [2*DW-1:0] cnt_q,
  output logic          pulse
);
  localparam int CW = 2 * DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q <= '0;
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (lo_wr) max_q[DW-1:0]  <= wdata;
      if (hi_wr) max_q[CW-1:DW] <= wdata;
      if (run) begin
        if (cnt_q == '0) begin
          cnt_q <= max_q;
          pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end else begin
        if (lo_wr) cnt_q[DW-1:0]  <= wdata;
        if (hi_wr) cnt_q[CW-1:DW] <= wdata;
      end
    end
  end
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int NTMR = 8,
  parameter int DW   = 32,
  parameter int AW   = 9
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                ctrl_q,
  input  logic [NTMR-1:0][2*DW-1:0]    max_arr,
  input  logic [NTMR-1:0][2*DW-1:0]    cnt_arr,
  output logic [DW-1:0]                rdata
);
  localparam int CW = 2 * DW;
  logic [DW-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    if (addr == AW'(CTRL_OFS)) rd_nxt = ctrl_q;
    for (int i = 0; i < NTMR; i++) begin
      if (addr == AW'(MAXLO_OFS + i)) rd_nxt = max_arr[i][DW-1:0];
      if (addr == AW'(MAXHI_OFS + i)) rd_nxt = max_arr[i][CW-1:DW];
      if (addr == AW'(CNTLO_OFS + i)) rd_nxt = cnt_arr[i][DW-1:0];
      if (addr == AW'(CNTHI_OFS + i)) rd_nxt = cnt_arr[i][CW-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_nxt;
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NTMR = 8,
  parameter int DW   = 32,
  parameter int AW   = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [NTMR-1:0] tmr_irq
);
  localparam int CW = 2 * DW;

  logic                      ctrl_wr;
  logic [DW-1:0]             ctrl_q;
  logic [NTMR-1:0]           lo_wr, hi_wr, en_vec, max_wr_vec;
  logic [NTMR-1:0][CW-1:0]   max_arr, cnt_arr;

  tmr_decode #(.NTMR(NTMR), .AW(AW)) u_dec (
    .wr_en(wr_en), .addr(addr), .ctrl_wr(ctrl_wr), .lo_wr(lo_wr), .hi_wr(hi_wr)
  );

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata;
  end

  assign en_vec     = ctrl_q[RUN_LSB +: NTMR];
  assign max_wr_vec = lo_wr | hi_wr;

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    tmr_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .run(en_vec[i]),
      .lo_wr(lo_wr[i]), .hi_wr(hi_wr[i]), .wdata(wdata),
      .max_q(max_arr[i]), .cnt_q(cnt_arr[i]), .pulse(tmr_irq[i])
    );
  end

  tmr_rdmux #(.NTMR(NTMR), .DW(DW), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .ctrl_q(ctrl_q),
    .max_arr(max_arr), .cnt_arr(cnt_arr), .rdata(rdata)
  );
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NTMR = 8,
  parameter int DW   = 32,
  parameter int AW   = 9
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rd_en,
  input logic [AW-1:0]              addr,
  input logic [DW-1:0]              rdata,
  input logic [NTMR-1:0]            tmr_irq,
  input logic [NTMR-1:0]            en_vec,
  input logic [NTMR-1:0]            max_wr_vec,
  input logic [NTMR-1:0][2*DW-1:0]  max_arr,
  input logic [NTMR-1:0][2*DW-1:0]  cnt_arr
);
  localparam int CW = 2 * DW;

  for (genvar k = 0; k < NTMR; k++) begin : g_chk
    p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
      (en_vec[k] && cnt_arr[k] != '0) |=> (cnt_arr[k] == $past(cnt_arr[k]) - CW'(1)));
    p_reload_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      (en_vec[k] && cnt_arr[k] == '0) |=> (cnt_arr[k] == $past(max_arr[k]) && tmr_irq[k]));
    p_pulse_cause_r6: assert property (@(posedge clk) disable iff (rst)
      tmr_irq[k] |-> ($past(en_vec[k]) && $past(cnt_arr[k]) == '0));
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!en_vec[k] && !max_wr_vec[k]) |=> $stable(cnt_arr[k]));
  end

  p_undecoded_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == '1) |=> (rdata == '0));
endmodule

bind tmr_bank tmr_bank_chk #(.NTMR(NTMR), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .tmr_irq(tmr_irq), .en_vec(en_vec), .max_wr_vec(max_wr_vec),
  .max_arr(max_arr), .cnt_arr(cnt_arr)
);

// File: tb/sim_tmr_bank.sv
`timescale 1ns/1ps
module sim_tmr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  tmr_irq;

  int     n_chk = 0;
  int     n_bad = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  typedef struct { int tmr; longint at; } ev_t;
  ev_t evq[$];

  tmr_bank u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
               .wdata(wdata), .rdata(rdata), .tmr_irq(tmr_irq));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on edge number e.
  task automatic wr(input logic [8:0] a, input logic [31:0] d, output longint e);
    e = cyc + 1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr0(input logic [8:0] a, input logic [31:0] d);
    longint e;
    wr(a, d, e);
  endtask

  // Samples on the next edge; result read at the following falling edge.
  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic wait_edge(input longint m);
    while (cyc < m - 1) @(negedge clk);
  endtask

  task automatic push(input int t, input longint at);
    ev_t ev;
    ev.tmr = t; ev.at = at;
    evq.push_back(ev);
  endtask

  // Scoreboard monitor for expiry pulses (R6, R10).
  always @(negedge clk) begin
    if (!rst && !done) begin
      while (evq.size() > 0 && evq[0].at < cyc) begin
        n_chk++; n_bad++;
        $display("FAIL R6 missed pulse: actual none expected timer %0d at %0d", evq[0].tmr, evq[0].at);
        void'(evq.pop_front());
      end
      for (int k = 0; k < 8; k++) begin
        if (tmr_irq[k]) begin
          n_chk++;
          if (evq.size() == 0) begin
            n_bad++;
            $display("FAIL R10 unexpected pulse: actual timer %0d at %0d expected none", k, cyc);
          end else begin
            if (evq[0].tmr != k || evq[0].at != cyc) begin
              n_bad++;
              $display("FAIL R6 pulse: actual timer %0d at %0d expected timer %0d at %0d",
                       k, cyc, evq[0].tmr, evq[0].at);
            end
            void'(evq.pop_front());
          end
        end
      end
    end
  end

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, h1, l1, h2;
    longint e, e5;
    logic [63:0] v5;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq", {56'd0, tmr_irq}, 64'd0);
    rd(9'h000, d); check("R1 ctrl", d, 0);
    rd(9'h123, d); check("R1 count lo t3", d, 0);
    rd(9'h117, d); check("R1 limit hi t7", d, 0);

    // R3 / R4: limit words on a stopped timer preset the count
    wr0(9'h103, 32'h1234_5678);
    wr0(9'h113, 32'h9ABC_DEF0);
    rd(9'h103, d); check("R3 limit lo t3", d, 32'h1234_5678);
    rd(9'h113, d); check("R3 limit hi t3", d, 32'h9ABC_DEF0);
    rd(9'h123, d); check("R4 preset count lo t3", d, 32'h1234_5678);
    rd(9'h133, d); check("R4 preset count hi t3", d, 32'h9ABC_DEF0);

    // R8: count words are not writable
    wr0(9'h123, 32'h0);
    wr0(9'h133, 32'h0);
    rd(9'h123, d); check("R8 count lo t3 after write", d, 32'h1234_5678);
    rd(9'h133, d); check("R8 count hi t3 after write", d, 32'h9ABC_DEF0);

    // R9: undecoded offsets read zero
    rd(9'h1FF, d); check("R9 undecoded 0x1FF", d, 0);
    rd(9'h140, d); check("R9 undecoded 0x140", d, 0);

    // R2 / R7: bits outside the run field start nothing
    wr0(9'h000, 32'hFFFF_00FF);
    repeat (10) @(negedge clk);
    rd(9'h123, d); check("R2 count t3 held with non-run bits", d, 32'h1234_5678);
    rd(9'h000, d); check("R2 ctrl readback", d, 32'hFFFF_00FF);
    wr0(9'h000, 32'h0);

    // R6 / R7: limit 4 on timer 2, period 5, stop mid-period
    wr0(9'h102, 32'd4);
    wr(9'h000, 32'h1 << 10, e);
    push(2, e + 5); push(2, e + 10); push(2, e + 15);
    wait_edge(e + 17);
    wr0(9'h000, 32'h0);
    repeat (6) @(negedge clk);
    rd(9'h122, d); check("R7 count t2 frozen", d, 32'd2);
    rd(9'h123, d); check("R10 t3 untouched", d, 32'h1234_5678);

    // R5: borrow across halves, timer 5 count 0x1_00000002
    wr0(9'h105, 32'd2);
    wr0(9'h115, 32'd1);
    wr(9'h000, 32'h1 << 13, e5);
    wait_edge(e5 + 2);
    rd(9'h135, h1);
    rd(9'h125, l1);
    rd(9'h135, h2);
    check("R5 first high read", h1, 32'd1);
    check("R5 low read", l1, 32'd0);
    check("R5 second high read after borrow", h2, 32'd0);
    rd(9'h125, d); check("R5 low after borrow", d, 32'hFFFF_FFFE);

    // R4: limit write to a running timer leaves the count alone
    wait_edge(e5 + 10);
    wr0(9'h105, 32'd7);
    rd(9'h125, d);
    v5 = 64'h1_0000_0002 - 64'd10;
    check("R4 running count unaffected", d, v5[31:0]);
    rd(9'h105, d); check("R3 limit lo t5 rewritten", d, 32'd7);

    // R6 / R10: limit 0 on timer 0 and limit 2 on timer 7 together
    wr0(9'h107, 32'd2);
    wr(9'h000, (32'h1 << 8) | (32'h1 << 15) | (32'h1 << 13), e);
    for (int m = 1; m <= 7; m++) begin
      push(0, e + m);
      if (m % 3 == 0) push(7, e + m);
    end
    wait_edge(e + 7);
    wr0(9'h000, 32'h1 << 13);
    repeat (4) @(negedge clk);
    rd(9'h127, d); check("R7 count t7 frozen", d, 32'd1);
    rd(9'h120, d); check("R6 count t0 limit zero", d, 32'd0);

    repeat (5) @(negedge clk);
    check("R6 all expected pulses seen", evq.size(), 0);
    finish_run();
  end
endmodule